// File: doc/BRIEF.md
# Configurable Transmit Framer

The block turns bytes written by a host into one serial bit stream for a downstream modulator. The host writes a byte into a holding register. On a later bit-rate strobe the byte moves into a shift register, and from then on exactly one bit leaves on `txLine` per strobe. A six-bit mode word picks the line format. In synchronous mode each byte goes out as eight raw bits. In asynchronous mode each byte is wrapped in a character with a start bit, seven or eight data bits, an optional parity bit and zero, one or two stop bits.

The host watches `readyFlag` to learn when the holding register can take the next byte. A bit slot may come up with no byte waiting. The block then sends mark (logic 1) and raises a sticky `underflowFlag`, which stays set until the host clears it. While `txEnable` is low the line rests at mark and any character in flight is dropped. A byte still waiting in the holding register is kept and goes out once transmission is enabled again.

Top module: `txf_top`

## Requirements
- R1: After reset `txLine` is 1, `readyFlag` is 1 and `underflowFlag` is 0.
- R2: With `modeCfg[5]`=0 (synchronous), the loaded byte goes out as 8 bits, bit 0 first, with no start, parity or stop bits.
- R3: With `modeCfg[5]`=1 (asynchronous), each character opens with one start bit of 0. The data bits follow, bit 0 first: 7 bits when `modeCfg[0]`=0 and 8 bits when `modeCfg[0]`=1.
- R4: `modeCfg[2:1]` selects parity. 00 and 11 send no parity bit. 01 sends an even parity bit and 10 sends an odd parity bit. Parity is placed right after the data bits and covers only the data bits that are sent.
- R5: `modeCfg[4:3]` selects the number of stop bits, all at 1: 00 sends none, 01 sends one, and 10 or 11 send two. The next character may follow with no gap.
- R6: A write (`wrStrobe`) makes `readyFlag` 0 on the next cycle. When the held byte moves into the shift register, `readyFlag` returns to 1 on the next cycle.
- R7: Suppose a strobe arrives while enabled, the previous character is finished and no byte is held. Then that bit is 1 and `underflowFlag` is set. Mark is sent on every such strobe until a byte is written.
- R8: `underflowFlag` stays set until a `clrUnderflow` pulse. If a new underflow and a clear fall in the same cycle, the flag stays set.
- R9: While `txEnable` is 0, `txLine` is 1 from the next cycle on and strobes have no effect. The character in flight is abandoned. A byte in the holding register is kept and is the first thing sent after re-enable.
- R10: `txLine` changes only in the cycle after an enabled `bitStrobe` or after `txEnable` goes low. Between strobes it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bitStrobe | input | 1 | Single-cycle bit-rate strobe |
| txEnable | input | 1 | Transmit enable; low forces mark |
| modeCfg | input | 6 | Format: [5] async, [4:3] stops, [2:1] parity, [0] eight data bits |
| wrStrobe | input | 1 | Host write into the holding register |
| wrData | input | 8 | Byte to write |
| clrUnderflow | input | 1 | Clears the underflow flag |
| txLine | output | 1 | Serial output toward the modulator |
| readyFlag | output | 1 | Holding register can take a byte |
| underflowFlag | output | 1 | Sticky: a bit slot found no data |

## Verification
Some properties are checked by assertions on every cycle. A load in asynchronous mode always puts a 0 on the line, and a synchronous load always puts the held bit 0 on the line. The line stays steady between strobes and falls to mark after disable. The ready flag drops after a write, underflow stays sticky, and it rises only on an enabled strobe. Other behaviour needs the bench's scenarios to show it: the full bit order of each format, the parity value, the stop-bit count, back-to-back characters with no gap, a byte kept across a disable, and a set and a clear of underflow landing in the same cycle. The bench compares every emitted bit against a queue of expected bits built from the requirements.

// File: rtl/txf_pkg.sv
package txf_pkg;

  localparam int DATA_W    = 8;
  localparam int START_W   = 1;
  localparam int PARITY_W  = 1;
  localparam int STOP_MAX  = 2;
  localparam int FRAME_MAX = START_W + DATA_W + PARITY_W + STOP_MAX;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  // Packed so that a cast from the 6-bit mode word lines up field for field.
  typedef struct packed {
    logic       asyncMode;  // [5]
    logic [1:0] stopSel;    // [4:3]
    logic [1:0] parSel;     // [2:1]
    logic       eightBits;  // [0]
  } modeT;

  typedef struct packed {
    logic loadFrame;  // move the held byte into the shifter, emit its first bit
    logic shiftBit;   // emit the next bit of the current character
    logic markFill;   // slot with no data: emit mark
    logic forceIdle;  // transmitter disabled
  } ctlStrobeT;

  function automatic logic parityOn(input modeT m);
    return (m.parSel == 2'b01) || (m.parSel == 2'b10);
  endfunction

  function automatic logic [CNT_W-1:0] stopCount(input modeT m);
    case (m.stopSel)
      2'b00:   return CNT_W'(0);
      2'b01:   return CNT_W'(1);
      default: return CNT_W'(STOP_MAX);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] dataCount(input modeT m);
    return m.eightBits ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
  endfunction

  function automatic logic [CNT_W-1:0] frameLen(input modeT m);
    if (!m.asyncMode) return CNT_W'(DATA_W);
    return CNT_W'(START_W) + dataCount(m) + CNT_W'(parityOn(m)) + stopCount(m);
  endfunction

endpackage

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import txf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bitStrobe,
  input  logic      txEnable,
  input  modeT      mode,
  input  logic      wrStrobe,
  input  logic      clrUnderflow,
  output ctlStrobeT ctl,
  output logic      readyFlag,
  output logic      underflowFlag
);

  logic             holdFull;
  logic [CNT_W-1:0] bitsLeft;
  logic             underflowQ;

  always_comb begin
    ctl = '0;
    if (!txEnable) begin
      ctl.forceIdle = 1'b1;
    end else if (bitStrobe) begin
      if (bitsLeft != '0)  ctl.shiftBit  = 1'b1;
      else if (holdFull)   ctl.loadFrame = 1'b1;
      else                 ctl.markFill  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitsLeft <= '0;
    end else if (ctl.forceIdle) begin
      bitsLeft <= '0;
    end else if (ctl.loadFrame) begin
      bitsLeft <= frameLen(mode) - CNT_W'(1);
    end else if (ctl.shiftBit) begin
      bitsLeft <= bitsLeft - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              holdFull <= 1'b0;
    else if (wrStrobe)       holdFull <= 1'b1;
    else if (ctl.loadFrame)  holdFull <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             underflowQ <= 1'b0;
    else if (ctl.markFill)  underflowQ <= 1'b1;
    else if (clrUnderflow)  underflowQ <= 1'b0;
  end

  assign readyFlag     = ~holdFull;
  assign underflowFlag = underflowQ;

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrStrobe |=> !readyFlag);

  // R8
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underflowFlag && !clrUnderflow) |=> underflowFlag);

  // R7
  underflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflowFlag) |-> $past(bitStrobe && txEnable && readyFlag));

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitsLeft <= CNT_W'(FRAME_MAX - 1));

endmodule

// File: rtl/txf_dp.sv
module txf_dp
  import txf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobeT         ctl,
  input  modeT              mode,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              txLine
);

  logic [DATA_W-1:0]    holdReg;
  logic [FRAME_MAX-1:0] frameVec;
  logic [FRAME_MAX-1:0] shiftReg;
  logic                 txQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        holdReg <= '0;
    else if (wrStrobe) holdReg <= wrData;
  end

  // Character image, bit 0 first on the line; unused upper positions are mark.
  always_comb begin
    logic             parRaw;
    logic [CNT_W-1:0] nData;
    frameVec = '1;
    parRaw   = 1'b0;
    nData    = dataCount(mode);
    if (!mode.asyncMode) begin
      frameVec[DATA_W-1:0] = holdReg;
    end else begin
      frameVec[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
        if (CNT_W'(i) < nData) begin
          frameVec[START_W + i] = holdReg[i];
          parRaw = parRaw ^ holdReg[i];
        end
      end
      if (parityOn(mode))
        frameVec[START_W + int'(nData)] = (mode.parSel == 2'b10) ? ~parRaw : parRaw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txQ      <= 1'b1;
      shiftReg <= '1;
    end else if (ctl.forceIdle || ctl.markFill) begin
      txQ      <= 1'b1;
      shiftReg <= '1;
    end else if (ctl.loadFrame) begin
      txQ      <= frameVec[0];
      shiftReg <= {1'b1, frameVec[FRAME_MAX-1:1]};
    end else if (ctl.shiftBit) begin
      txQ      <= shiftReg[0];
      shiftReg <= {1'b1, shiftReg[FRAME_MAX-1:1]};
    end
  end

  assign txLine = txQ;

  // R3
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.loadFrame && mode.asyncMode) |=> !txLine);

  // R2
  sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.loadFrame && !mode.asyncMode) |=> (txLine == $past(holdReg[0])));

  // R9
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.forceIdle |=> txLine);

  // R10
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == '0) |=> $stable(txLine));

endmodule

// File: rtl/txf_top.sv
module txf_top
  import txf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bitStrobe,
  input  logic              txEnable,
  input  logic [5:0]        modeCfg,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              clrUnderflow,
  output logic              txLine,
  output logic              readyFlag,
  output logic              underflowFlag
);

  modeT      modeW;
  ctlStrobeT ctlW;

  assign modeW = modeT'(modeCfg);

  txf_ctrl i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .bitStrobe    (bitStrobe),
    .txEnable     (txEnable),
    .mode         (modeW),
    .wrStrobe     (wrStrobe),
    .clrUnderflow (clrUnderflow),
    .ctl          (ctlW),
    .readyFlag    (readyFlag),
    .underflowFlag(underflowFlag)
  );

  txf_dp i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctlW),
    .mode     (modeW),
    .wrStrobe (wrStrobe),
    .wrData   (wrData),
    .txLine   (txLine)
  );

  // R1
  reset_mark_chk: assert property (@(posedge clk) $fell(rst_n) |=> txLine);

endmodule

// File: tb/test_txf_top.sv
module test_txf_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bitStrobe = 1'b0;
  logic       txEnable = 1'b0;
  logic [5:0] modeCfg = 6'b000000;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       clrUnderflow = 1'b0;
  logic       txLine, readyFlag, underflowFlag;

  int checks = 0;
  int errors = 0;
  int pendingBits = 0;
  bit expBits[$];
  string expTags[$];

  always #5 clk = ~clk;

  txf_top i_txf_top (
    .clk(clk), .rst_n(rst_n), .bitStrobe(bitStrobe), .txEnable(txEnable),
    .modeCfg(modeCfg), .wrStrobe(wrStrobe), .wrData(wrData),
    .clrUnderflow(clrUnderflow), .txLine(txLine), .readyFlag(readyFlag),
    .underflowFlag(underflowFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pushBit(input bit b, input string tag);
    expBits.push_back(b);
    expTags.push_back(tag);
    pendingBits++;
  endtask

  // Expected line bits for one character, built from the requirements.
  task automatic pushFrame(input logic [7:0] d, input logic [5:0] m, input int limit);
    bit seq[$];
    string tg;
    int n;
    bit p;
    if (!m[5]) begin
      for (int i = 0; i < 8; i++) seq.push_back(d[i]);
      tg = "R2";
    end else begin
      n = m[0] ? 8 : 7;
      p = 1'b0;
      seq.push_back(1'b0);
      for (int i = 0; i < n; i++) begin seq.push_back(d[i]); p ^= d[i]; end
      if (m[2:1] == 2'b01) seq.push_back(p);
      if (m[2:1] == 2'b10) seq.push_back(~p);
      if (m[4:3] != 2'b00) seq.push_back(1'b1);
      if (m[4:3] == 2'b10 || m[4:3] == 2'b11) seq.push_back(1'b1);
      tg = "R3/R4/R5";
    end
    for (int i = 0; i < seq.size() && i < limit; i++) pushBit(seq[i], tg);
  endtask

  task automatic strobe();
    @(negedge clk); bitStrobe = 1'b1;
    @(negedge clk); bitStrobe = 1'b0;
    if (pendingBits > 0 && txEnable) pendingBits--;
  endtask

  task automatic drain();
    while (pendingBits > 0) strobe();
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk); wrStrobe = 1'b1; wrData = d;
    @(negedge clk); wrStrobe = 1'b0;
  endtask

  task automatic clearUf();
    @(negedge clk); clrUnderflow = 1'b1;
    @(negedge clk); clrUnderflow = 1'b0;
  endtask

  task automatic sendPair(input logic [5:0] m, input logic [7:0] b0, input logic [7:0] b1);
    modeCfg = m;
    writeByte(b0);
    pushFrame(b0, m, 99);
    strobe();
    chk("R6 ready after load", readyFlag, 1);
    writeByte(b1);
    pushFrame(b1, m, 99);
    drain();
  endtask

  // Monitor: each enabled strobe produces one bit, compared with the queue.
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && txEnable && bitStrobe) begin
        @(negedge clk);
        checks++;
        if (expBits.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected bit actual=%0b expected=none", txLine);
        end else begin
          bit e;
          string t;
          e = expBits.pop_front();
          t = expTags.pop_front();
          if (txLine !== e) begin
            errors++;
            $display("FAIL %s line bit actual=%0b expected=%0b", t, txLine, e);
          end
        end
      end
    end
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 txLine", txLine, 1);
    chk("R1 ready", readyFlag, 1);
    chk("R1 underflow", underflowFlag, 0);
    rst_n = 1'b1;
    @(negedge clk);
    txEnable = 1'b1;

    // R2: synchronous, two bytes back to back
    modeCfg = 6'b000000;
    writeByte(8'hA5);
    chk("R6 ready after write", readyFlag, 0);
    pushFrame(8'hA5, modeCfg, 99);
    strobe();
    chk("R6 ready after load", readyFlag, 1);
    writeByte(8'h3C);
    pushFrame(8'h3C, modeCfg, 99);
    drain();

    // R7: no data available
    pushBit(1'b1, "R7");
    strobe();
    chk("R7 underflow set", underflowFlag, 1);
    pushBit(1'b1, "R7");
    strobe();
    repeat (4) @(negedge clk);
    chk("R8 sticky", underflowFlag, 1);
    // R8: set and clear in same cycle keeps flag
    pushBit(1'b1, "R8");
    @(negedge clk); bitStrobe = 1'b1; clrUnderflow = 1'b1;
    @(negedge clk); bitStrobe = 1'b0; clrUnderflow = 1'b0; pendingBits--;
    chk("R8 set wins", underflowFlag, 1);
    clearUf();
    chk("R8 cleared", underflowFlag, 0);

    // R3 R4 R5: asynchronous formats
    sendPair(6'b101011, 8'h96, 8'h01); // 8 data, even, 1 stop
    sendPair(6'b110100, 8'hD3, 8'h7F); // 7 data, odd, 2 stop
    sendPair(6'b100001, 8'h00, 8'hFF); // 8 data, none, 0 stop
    sendPair(6'b111110, 8'h55, 8'h2A); // 7 data, none(11), 2 stop(11)
    sendPair(6'b101101, 8'hE1, 8'h33); // 8 data, odd, 1 stop
    chk("R7 no underflow while fed", underflowFlag, 0);

    // R10 and R9: hold between strobes, then disable mid-character
    modeCfg = 6'b101001;
    writeByte(8'h5A);
    pushFrame(8'h5A, modeCfg, 3);
    strobe();
    repeat (4) @(negedge clk);
    chk("R10 start bit held", txLine, 0);
    strobe();
    strobe();
    writeByte(8'hC3);
    @(negedge clk); txEnable = 1'b0;
    @(negedge clk);
    chk("R9 mark when disabled", txLine, 1);
    strobe();
    chk("R9 strobe ignored line", txLine, 1);
    chk("R9 strobe ignored uf", underflowFlag, 0);
    chk("R9 byte kept", readyFlag, 0);
    @(negedge clk); txEnable = 1'b1;
    pushFrame(8'hC3, modeCfg, 99);
    drain();
    chk("R9 held byte sent", readyFlag, 1);

    repeat (3) @(negedge clk);
    chk("queue empty", expBits.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule